// File: doc/BRIEF.md
# Floating-Point Compare to Condition Flags

This unit compares two IEEE-754 operands and turns the outcome into a four-bit condition code. The caller selects the format with `dbl_i`. In single precision (`dbl_i` = 0), only the low 32 bits of each operand bus are used. In double precision (`dbl_i` = 1), all 64 bits are used. The result has one of four relations: equal, less than, greater than, or unordered. Unordered means at least one operand is a NaN.

`signal_i` selects one of two compare variants. Both variants give the same flags. They differ only in when they raise the invalid-operation bit. The quiet variant raises it only for a signalling NaN. The signalling variant raises it for any NaN. When `ftz_i` is set, subnormal inputs are first treated as zeros of the same sign.

The unit takes one register stage. A request presented with `in_valid_i` gives its result one clock later, with `out_valid_o` high. The outputs hold until the next request arrives.

Top module: `fcmp_nzcv`

## Requirements
- R1: Equal operands give `nzcv_o` = 4'b0110. The bits are N, Z, C, V from bit 3 down to bit 0. +0 and -0 count as equal.
- R2: When operand A is less than operand B, `nzcv_o` = 4'b1000.
- R3: When operand A is greater than operand B, `nzcv_o` = 4'b0010.
- R4: When either operand is a NaN, `nzcv_o` = 4'b0011. A NaN has an all-ones exponent and a non-zero fraction.
- R5: With `dbl_i` = 0, operands are the single-precision values in bits [31:0], and bits [63:32] have no effect. With `dbl_i` = 1, operands are the double-precision values in bits [63:0].
- R6: With `signal_i` = 0, `invalid_o` is 1 only when an operand is a signalling NaN. A signalling NaN is a NaN whose fraction MSB is 0.
- R7: With `signal_i` = 1, `invalid_o` is 1 exactly when an operand is any NaN. The flags match those of the quiet variant.
- R8: With `ftz_i` = 1, a subnormal operand (exponent 0, fraction non-zero) compares as a zero of its own sign. With `ftz_i` = 0, it compares by its value. NaN handling is the same with either setting.
- R9: A request sampled with `in_valid_i` high at a rising edge shows its result after that edge, with `out_valid_o` = 1. An edge where `in_valid_i` is low leaves `nzcv_o` and `invalid_o` unchanged and sets `out_valid_o` = 0.
- R10: While `rst_n` is low, `out_valid_o`, `nzcv_o` and `invalid_o` are 0. This reset is asynchronous.
- R11: Infinities are ordered as follows: -inf is below every finite value, +inf is above every finite value, and an infinity equals an infinity of the same sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request strobe |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision in bits [31:0] |
| signal_i | input | 1 | 1 = signalling compare, 0 = quiet compare |
| ftz_i | input | 1 | Treat subnormal inputs as zero |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| nzcv_o | output | 4 | Condition flags N, Z, C, V (bit 3 down to bit 0) |
| invalid_o | output | 1 | Invalid-operation exception |

## Verification
The vectors are grouped so that each group isolates one decision:
- **Ordering:** same-sign and mixed-sign finite pairs separate the magnitude-ordering path from the sign-ordering path. Signed zeros and infinities probe the edges of both paths.
- **NaN and exception bit:** quiet and signalling NaNs go through both compare variants. This shows that the flags stay the same while only the invalid bit follows the mode.
- **Precision select:** some operand pairs have different high and low words, so the single-precision and double-precision results differ. This exposes a wrong format select or a wrong slice.
- **Flush-to-zero:** subnormal pairs are sent with and without flushing to show that flushing turns greater-than into equal.
- **Timing:** directed steps cover hold while idle and asynchronous reset in mid-run.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_LT = 2'd1,
      REL_GT = 2'd2,
      REL_UN = 2'd3
   } fcmp_rel_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
      logic sign;
   } fcmp_class_t;

   localparam logic [3:0] NZCV_EQ = 4'b0110;
   localparam logic [3:0] NZCV_LT = 4'b1000;
   localparam logic [3:0] NZCV_GT = 4'b0010;
   localparam logic [3:0] NZCV_UN = 4'b0011;

   function automatic logic [3:0] rel_to_nzcv(input fcmp_rel_e rel);
      case (rel)
         REL_EQ:  return NZCV_EQ;
         REL_LT:  return NZCV_LT;
         REL_GT:  return NZCV_GT;
         default: return NZCV_UN;
      endcase
   endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int VAL_W = EXP_W + MAN_W + 1,
   localparam int MAG_W = EXP_W + MAN_W
) (
   input  logic [VAL_W-1:0] value_i,
   input  logic             ftz_i,
   output fcmp_class_t      cls_o,
   output logic [MAG_W-1:0] mag_o
);

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fcmp_classify: EXP_W must be at least 2");
      end
      if (MAN_W < 2) begin : g_bad_man
         $error("fcmp_classify: MAN_W must be at least 2");
      end
   endgenerate

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_ones;
   logic             exp_zero;
   logic             man_nz;
   logic             nan_w;
   logic             zero_w;

   assign exp_f    = value_i[VAL_W-2:MAN_W];
   assign man_f    = value_i[MAN_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_zero = ~|exp_f;
   assign man_nz   = |man_f;
   assign nan_w    = exp_ones & man_nz;
   assign zero_w   = exp_zero & (~man_nz | ftz_i);

   always_comb begin
      cls_o.sign    = value_i[VAL_W-1];
      cls_o.is_nan  = nan_w;
      cls_o.is_snan = nan_w & ~man_f[MAN_W-1];
      cls_o.is_zero = zero_w;
      mag_o         = zero_w ? '0 : value_i[MAG_W-1:0];
   end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  fcmp_class_t      cls_a_i,
   input  fcmp_class_t      cls_b_i,
   input  logic [MAG_W-1:0] mag_a_i,
   input  logic [MAG_W-1:0] mag_b_i,
   output fcmp_rel_e        rel_o
);

   logic mag_eq;
   logic mag_lt;

   assign mag_eq = (mag_a_i == mag_b_i);
   assign mag_lt = (mag_a_i < mag_b_i);

   always_comb begin
      if (cls_a_i.is_nan || cls_b_i.is_nan) begin
         rel_o = REL_UN;
      end else if (cls_a_i.is_zero && cls_b_i.is_zero) begin
         rel_o = REL_EQ;
      end else if (cls_a_i.sign != cls_b_i.sign) begin
         rel_o = cls_a_i.sign ? REL_LT : REL_GT;
      end else if (mag_eq) begin
         rel_o = REL_EQ;
      end else if (mag_lt ^ cls_a_i.sign) begin
         rel_o = REL_LT;
      end else begin
         rel_o = REL_GT;
      end
   end

   always_comb begin
      if (cls_a_i.is_zero && cls_b_i.is_zero && !cls_a_i.is_nan && !cls_b_i.is_nan) begin
         assert_zero_equal_R1 : assert (rel_o == REL_EQ);
      end
   end

endmodule

// File: rtl/fcmp_nzcv.sv
module fcmp_nzcv
   import fcmp_pkg::*;
#(
   parameter int SP_EXP  = 8,
   parameter int SP_MAN  = 23,
   parameter int DP_EXP  = 11,
   parameter int DP_MAN  = 52,
   parameter bit OUT_REG = 1'b1,
   localparam int SP_W = SP_EXP + SP_MAN + 1,
   localparam int DP_W = DP_EXP + DP_MAN + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid_i,
   input  logic            dbl_i,
   input  logic            signal_i,
   input  logic            ftz_i,
   input  logic [DP_W-1:0] op_a_i,
   input  logic [DP_W-1:0] op_b_i,
   output logic            out_valid_o,
   output logic [3:0]      nzcv_o,
   output logic            invalid_o
);

   localparam int NUM_OPS = 2;

   generate
      if (SP_W > DP_W) begin : g_bad_width
         $error("fcmp_nzcv: single format wider than double format");
      end
   endgenerate

   logic [DP_W-1:0]   ops     [NUM_OPS];
   fcmp_class_t       cls_sp  [NUM_OPS];
   fcmp_class_t       cls_dp  [NUM_OPS];
   fcmp_class_t       cls_sel [NUM_OPS];
   logic [SP_W-2:0]   mag_sp  [NUM_OPS];
   logic [DP_W-2:0]   mag_dp  [NUM_OPS];

   assign ops[0] = op_a_i;
   assign ops[1] = op_b_i;

   generate
      for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
         fcmp_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) i_cls_sp (
            .value_i (ops[k][SP_W-1:0]),
            .ftz_i   (ftz_i),
            .cls_o   (cls_sp[k]),
            .mag_o   (mag_sp[k])
         );
         fcmp_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) i_cls_dp (
            .value_i (ops[k]),
            .ftz_i   (ftz_i),
            .cls_o   (cls_dp[k]),
            .mag_o   (mag_dp[k])
         );
         assign cls_sel[k] = dbl_i ? cls_dp[k] : cls_sp[k];
      end
   endgenerate

   fcmp_rel_e rel_sp;
   fcmp_rel_e rel_dp;

   fcmp_order #(.MAG_W(SP_W-1)) i_order_sp (
      .cls_a_i (cls_sp[0]),
      .cls_b_i (cls_sp[1]),
      .mag_a_i (mag_sp[0]),
      .mag_b_i (mag_sp[1]),
      .rel_o   (rel_sp)
   );

   fcmp_order #(.MAG_W(DP_W-1)) i_order_dp (
      .cls_a_i (cls_dp[0]),
      .cls_b_i (cls_dp[1]),
      .mag_a_i (mag_dp[0]),
      .mag_b_i (mag_dp[1]),
      .rel_o   (rel_dp)
   );

   logic [3:0] nzcv_d;
   logic       inv_d;
   logic       any_nan;
   logic       any_snan;

   assign any_nan  = cls_sel[0].is_nan | cls_sel[1].is_nan;
   assign any_snan = cls_sel[0].is_snan | cls_sel[1].is_snan;
   assign nzcv_d   = rel_to_nzcv(dbl_i ? rel_dp : rel_sp);
   assign inv_d    = signal_i ? any_nan : any_snan;

   generate
      if (OUT_REG) begin : g_reg
         logic [3:0] nzcv_q;
         logic       inv_q;
         logic       vld_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               nzcv_q <= '0;
               inv_q  <= 1'b0;
               vld_q  <= 1'b0;
            end else begin
               vld_q <= in_valid_i;
               if (in_valid_i) begin
                  nzcv_q <= nzcv_d;
                  inv_q  <= inv_d;
               end
            end
         end

         assign nzcv_o      = nzcv_q;
         assign invalid_o   = inv_q;
         assign out_valid_o = vld_q;

         assert_latency_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            in_valid_i |=> out_valid_o);

         assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid_i |=> (!out_valid_o && $stable(nzcv_o) && $stable(invalid_o)));

         assert_invalid_only_unordered_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid_o && invalid_o) |-> (nzcv_o == NZCV_UN));

         assert_signal_any_nan_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && signal_i) |=> (invalid_o == (nzcv_o == NZCV_UN)));

         assert_flag_code_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o |-> (nzcv_o == NZCV_EQ || nzcv_o == NZCV_LT ||
                             nzcv_o == NZCV_GT || nzcv_o == NZCV_UN));
      end else begin : g_comb
         assign nzcv_o      = nzcv_d;
         assign invalid_o   = inv_d;
         assign out_valid_o = in_valid_i;
      end
   endgenerate

endmodule

// File: tb/test_fcmp_nzcv.sv
`timescale 1ns/1ps
module test_fcmp_nzcv;

   localparam logic [3:0] EQ = 4'b0110;
   localparam logic [3:0] LT = 4'b1000;
   localparam logic [3:0] GT = 4'b0010;
   localparam logic [3:0] UN = 4'b0011;
   localparam int NV = 33;

   // {dbl, signal, ftz, a[63:0], b[63:0], flags[3:0], invalid}
   localparam logic [135:0] VEC [NV] = '{
      {3'b000, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, EQ, 1'b0}, // R1
      {3'b000, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, EQ, 1'b0}, // R1 +0/-0
      {3'b000, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, LT, 1'b0}, // R2
      {3'b000, 64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, LT, 1'b0}, // R2
      {3'b000, 64'h0000_0000_BF80_0000, 64'h0000_0000_C000_0000, GT, 1'b0}, // R3
      {3'b000, 64'h0000_0000_4000_0000, 64'h0000_0000_3F80_0000, GT, 1'b0}, // R3
      {3'b000, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, UN, 1'b0}, // R4 R6
      {3'b000, 64'h0000_0000_3F80_0000, 64'h0000_0000_7F80_0001, UN, 1'b1}, // R6
      {3'b010, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, UN, 1'b1}, // R7
      {3'b010, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, EQ, 1'b0}, // R7
      {3'b010, 64'h0000_0000_7F80_0001, 64'h0000_0000_7FC0_0000, UN, 1'b1}, // R7
      {3'b000, 64'h0000_0000_7F80_0000, 64'h0000_0000_3F80_0000, GT, 1'b0}, // R11
      {3'b000, 64'h0000_0000_FF80_0000, 64'h0000_0000_BF80_0000, LT, 1'b0}, // R11
      {3'b000, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F80_0000, EQ, 1'b0}, // R11
      {3'b000, 64'h0000_0000_FF80_0000, 64'h0000_0000_7F80_0000, LT, 1'b0}, // R11
      {3'b100, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, LT, 1'b0}, // R5 R2
      {3'b100, 64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000, LT, 1'b0}, // R5 R2
      {3'b100, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, GT, 1'b0}, // R5 R3
      {3'b100, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, UN, 1'b0}, // R4 R6
      {3'b100, 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, UN, 1'b1}, // R6
      {3'b110, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, UN, 1'b1}, // R7
      {3'b100, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, EQ, 1'b0}, // R11
      {3'b000, 64'hDEAD_BEEF_3F80_0000, 64'h0123_4567_4000_0000, LT, 1'b0}, // R5
      {3'b100, 64'h3FF0_0000_0000_0000, 64'h3FF0_0001_0000_0000, LT, 1'b0}, // R5
      {3'b000, 64'h3FF0_0000_0000_0000, 64'h3FF0_0001_0000_0000, EQ, 1'b0}, // R5
      {3'b000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, GT, 1'b0}, // R8
      {3'b001, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, EQ, 1'b0}, // R8
      {3'b001, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0000, EQ, 1'b0}, // R8
      {3'b000, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_0000, LT, 1'b0}, // R8
      {3'b101, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, EQ, 1'b0}, // R8
      {3'b100, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, GT, 1'b0}, // R8
      {3'b001, 64'h0000_0000_7F80_0001, 64'h0000_0000_0000_0001, UN, 1'b1}, // R8 R6
      {3'b100, 64'h0000_0000_7FC0_0000, 64'h0000_0000_0000_0000, GT, 1'b0}  // R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid_i = 1'b0;
   logic        dbl_i = 1'b0;
   logic        signal_i = 1'b0;
   logic        ftz_i = 1'b0;
   logic [63:0] op_a_i = '0;
   logic [63:0] op_b_i = '0;
   logic        out_valid_o;
   logic [3:0]  nzcv_o;
   logic        invalid_o;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   fcmp_nzcv i_fcmp_nzcv (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (in_valid_i),
      .dbl_i       (dbl_i),
      .signal_i    (signal_i),
      .ftz_i       (ftz_i),
      .op_a_i      (op_a_i),
      .op_b_i      (op_b_i),
      .out_valid_o (out_valid_o),
      .nzcv_o      (nzcv_o),
      .invalid_o   (invalid_o)
   );

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(out_valid_o == 1'b0 && nzcv_o == 4'h0 && invalid_o == 1'b0, "R10 reset",
            {3'b0, out_valid_o, nzcv_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         {dbl_i, signal_i, ftz_i, op_a_i, op_b_i} = VEC[i][135:5];
         in_valid_i = 1'b1;
         @(negedge clk);
         check(out_valid_o == 1'b1, $sformatf("R9 valid vec %0d", i),
               {7'b0, out_valid_o}, 8'h01);
         check(nzcv_o == VEC[i][4:1], $sformatf("R1-4/R5/R8/R11 flags vec %0d", i),
               {4'b0, nzcv_o}, {4'b0, VEC[i][4:1]});
         check(invalid_o == VEC[i][0], $sformatf("R6/R7 invalid vec %0d", i),
               {7'b0, invalid_o}, {7'b0, VEC[i][0]});
      end

      // R9 hold: idle cycle with new operands must not change outputs
      in_valid_i = 1'b0;
      dbl_i = 1'b0; signal_i = 1'b1; ftz_i = 1'b0;
      op_a_i = 64'h0000_0000_3F80_0000;
      op_b_i = 64'h0000_0000_3F80_0000;
      @(negedge clk);
      check(out_valid_o == 1'b0, "R9 idle valid", {7'b0, out_valid_o}, 8'h00);
      check(nzcv_o == GT && invalid_o == 1'b0, "R9 hold",
            {3'b0, invalid_o, nzcv_o}, {4'b0, GT});
      @(negedge clk);
      check(nzcv_o == GT, "R9 hold second cycle", {4'b0, nzcv_o}, {4'b0, GT});

      // R9 back-to-back requests
      in_valid_i = 1'b1;
      @(negedge clk);
      check(nzcv_o == EQ && out_valid_o, "R9 b2b first", {3'b0, out_valid_o, nzcv_o}, {4'b1, EQ});
      op_a_i = 64'h0000_0000_7FC0_0000;
      @(negedge clk);
      check(nzcv_o == UN && invalid_o, "R7 b2b second", {3'b0, invalid_o, nzcv_o}, {4'b1, UN});

      // R10 asynchronous reset in mid-run
      #1 rst_n = 1'b0;
      #0.5;
      check(out_valid_o == 1'b0 && nzcv_o == 4'h0 && invalid_o == 1'b0, "R10 async reset",
            {3'b0, out_valid_o, nzcv_o}, 8'h00);
      in_valid_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid_o == 1'b0 && nzcv_o == 4'h0, "R10 after release",
            {3'b0, out_valid_o, nzcv_o}, 8'h00);

      finish_run();
   end

endmodule